// File: doc/BRIEF.md
# Per-Processor Cache Coherence Controller (Directory Protocol)

This block sits between one processor and the interconnect of a directory-based shared-memory multiprocessor. It keeps a small direct-mapped cache. Each line carries a coherence state of Invalid, Shared (read only) or Exclusive (read/write). Processor reads and writes that hit finish in the same cycle. Misses send a read-miss or write-miss request to the home directory, and the processor stalls until the home's data reply arrives. If the line being replaced is Exclusive, the controller first writes the victim back to home.

The home directory can also send commands to the controller. These are invalidate, fetch and fetch-with-invalidate. The controller handles them in the cycle they arrive, and a command that finds a dirty Exclusive line returns that line's data to home. A command takes priority over the processor state machine for that cycle. The request path holds while a command is present, so the controller never emits two messages in one cycle. Messages are assumed to arrive in the order they were sent.

State machine states: `F_IDLE` (hits are served; a miss leaves this state), `F_VICTIM` (write back an Exclusive victim), `F_REQUEST` (send the miss request) and `F_WAIT` (hold the processor until the data reply).
- A miss with an Exclusive victim takes `F_IDLE -> F_VICTIM -> F_REQUEST -> F_WAIT -> F_IDLE`.
- Any other miss takes `F_IDLE -> F_REQUEST -> F_WAIT -> F_IDLE`.
- `F_VICTIM` and `F_REQUEST` stay put in any cycle that carries a directory command.

Top module: `coh_cache`

## Requirements
- R1: After reset every line is Invalid, `msg_valid`, `cpu_done` and `cpu_stall` are low, and the first access to any address is a miss.
- R2: A read to a line that is Invalid or holds another tag sends a read miss (`msg_type` 0) carrying the request address. When the reply arrives, the reply data goes to `cpu_rdata` and the line becomes Shared.
- R3: A write to a line that is not Exclusive with the same tag (including a Shared line with that tag) sends a write miss (`msg_type` 1). When the reply arrives, the line becomes Exclusive and holds the write data.
- R4: A read to a Shared or Exclusive line with a matching tag, or a write to an Exclusive line with a matching tag, raises `cpu_done` in the same cycle and sends no message. A read returns the line data on `cpu_rdata`; a write stores the new data.
- R5: An invalidate command (`cmd_type` 0) on a matching Shared line makes it Invalid and sends no message.
- R6: A fetch command (`cmd_type` 1) on a matching Exclusive line sends, in the same cycle, a data write-back (`msg_type` 2) with the command address and the line data. The line then becomes Shared.
- R7: A fetch-with-invalidate command (`cmd_type` 2) on a matching Exclusive line sends the same write-back as R6. The line then becomes Invalid.
- R8: A miss that replaces an Exclusive line sends a write-back of the victim (victim address and data) in the cycle after the request is presented. The miss request follows in the next cycle.
- R9: While a miss is outstanding and the request is held, `cpu_stall` stays high and `cpu_done` stays low. Both change in the cycle that `reply_valid` is high: `cpu_done` rises and `cpu_stall` falls.
- R10: The controller ignores the following commands: a command whose tag does not match the line, an invalidate on an Exclusive line, a fetch on a Shared line, and `cmd_type` 3. An ignored command sends no message and leaves the line unchanged.
- R11: With no victim, the miss request goes out in the cycle after the request is presented. No message leaves the block while it waits for the reply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req_valid | input | 1 | Processor access request, held until `cpu_done` |
| cpu_req_write | input | 1 | 1 = write, 0 = read |
| cpu_req_addr | input | AW | Access address (low bits select the line) |
| cpu_req_wdata | input | DW | Write data |
| cpu_stall | output | 1 | Processor must wait |
| cpu_done | output | 1 | Access completes this cycle |
| cpu_rdata | output | DW | Read data, valid with `cpu_done` |
| cmd_valid | input | 1 | Directory command present |
| cmd_type | input | 2 | 0 invalidate, 1 fetch, 2 fetch-with-invalidate |
| cmd_addr | input | AW | Address the command targets |
| reply_valid | input | 1 | Data reply for the outstanding miss |
| reply_data | input | DW | Reply data from home memory |
| msg_valid | output | 1 | Outgoing message present |
| msg_type | output | 2 | 0 read miss, 1 write miss, 2 data write-back |
| msg_addr | output | AW | Message address |
| msg_data | output | DW | Write-back data |

## Verification
A wrong line state shows up at the ports the next time the processor or the directory touches that line. A state that is too strong turns a miss into a silent hit, or makes a fetch return a write-back that should not exist. A state that is too weak sends a spurious miss request one cycle after the access. Lost write data appears later, when a read or write-back returns an old value. For that reason the bench keeps a model of every line and of home memory, and compares each message, `cpu_done` and `cpu_rdata` in every cycle of every transaction.

// File: rtl/coh_pkg.sv
package coh_pkg;

    typedef enum logic [1:0] {
        LN_INV = 2'd0,
        LN_SHR = 2'd1,
        LN_EXC = 2'd2
    } line_st_e;

    localparam logic [1:0] MSG_RDMISS = 2'd0;
    localparam logic [1:0] MSG_WRMISS = 2'd1;
    localparam logic [1:0] MSG_WBACK  = 2'd2;

    localparam logic [1:0] CMD_INV       = 2'd0;
    localparam logic [1:0] CMD_FETCH     = 2'd1;
    localparam logic [1:0] CMD_FETCH_INV = 2'd2;

    typedef enum logic [1:0] {
        F_IDLE    = 2'd0,
        F_VICTIM  = 2'd1,
        F_REQUEST = 2'd2,
        F_WAIT    = 2'd3
    } fsm_e;

endpackage

// File: rtl/coh_line_array.sv
module coh_line_array
    import coh_pkg::*;
#(
    parameter int LINES = 4,
    parameter int TW    = 6,
    parameter int DW    = 16,
    parameter int IW    = $clog2(LINES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [IW-1:0] a_idx,
    output line_st_e      a_st,
    output logic [TW-1:0] a_tag,
    output logic [DW-1:0] a_data,
    input  logic [IW-1:0] b_idx,
    output line_st_e      b_st,
    output logic [TW-1:0] b_tag,
    output logic [DW-1:0] b_data,
    input  logic          c_we,
    input  logic [IW-1:0] c_idx,
    input  line_st_e      c_st,
    input  logic          m_we,
    input  logic [IW-1:0] m_idx,
    input  line_st_e      m_st,
    input  logic [TW-1:0] m_tag,
    input  logic [DW-1:0] m_data
);

    line_st_e      st_q   [LINES];
    logic [TW-1:0] tag_q  [LINES];
    logic [DW-1:0] data_q [LINES];

    // State: directory command update first, request path update wins on a tie
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int n = 0; n < LINES; n++) begin
                st_q[n] <= LN_INV;
            end
        end else begin
            if (c_we) begin
                st_q[c_idx] <= c_st;
            end
            if (m_we) begin
                st_q[m_idx] <= m_st;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (m_we) begin
            tag_q[m_idx]  <= m_tag;
            data_q[m_idx] <= m_data;
        end
    end

    assign a_st   = st_q[a_idx];
    assign a_tag  = tag_q[a_idx];
    assign a_data = data_q[a_idx];
    assign b_st   = st_q[b_idx];
    assign b_tag  = tag_q[b_idx];
    assign b_data = data_q[b_idx];

endmodule

// File: rtl/coh_cmd_unit.sv
module coh_cmd_unit
    import coh_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 16,
    parameter int IW = 2,
    parameter int TW = AW - IW
) (
    input  logic          cmd_valid,
    input  logic [1:0]    cmd_type,
    input  logic [AW-1:0] cmd_addr,
    output logic [IW-1:0] b_idx,
    input  line_st_e      b_st,
    input  logic [TW-1:0] b_tag,
    input  logic [DW-1:0] b_data,
    output logic          upd_we,
    output line_st_e      upd_st,
    output logic          wb_valid,
    output logic [AW-1:0] wb_addr,
    output logic [DW-1:0] wb_data
);

    logic match;

    always_comb begin
        b_idx    = cmd_addr[IW-1:0];
        match    = cmd_valid && (b_st != LN_INV) && (b_tag == cmd_addr[AW-1:IW]);
        upd_we   = 1'b0;
        upd_st   = b_st;
        wb_valid = 1'b0;
        wb_addr  = cmd_addr;
        wb_data  = b_data;
        if (match) begin
            case (cmd_type)
                CMD_INV: begin
                    if (b_st == LN_SHR) begin
                        upd_we = 1'b1;
                        upd_st = LN_INV;
                    end
                end
                CMD_FETCH: begin
                    if (b_st == LN_EXC) begin
                        upd_we   = 1'b1;
                        upd_st   = LN_SHR;
                        wb_valid = 1'b1;
                    end
                end
                CMD_FETCH_INV: begin
                    if (b_st == LN_EXC) begin
                        upd_we   = 1'b1;
                        upd_st   = LN_INV;
                        wb_valid = 1'b1;
                    end
                end
                default: begin
                    upd_we = 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/coh_miss_fsm.sv
module coh_miss_fsm
    import coh_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 16,
    parameter int IW = 2,
    parameter int TW = AW - IW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cpu_req_valid,
    input  logic          cpu_req_write,
    input  logic [AW-1:0] cpu_req_addr,
    input  logic [DW-1:0] cpu_req_wdata,
    input  logic          cmd_busy,
    input  logic          reply_valid,
    input  logic [DW-1:0] reply_data,
    output logic [IW-1:0] a_idx,
    input  line_st_e      a_st,
    input  logic [TW-1:0] a_tag,
    input  logic [DW-1:0] a_data,
    output logic          m_we,
    output logic [IW-1:0] m_idx,
    output line_st_e      m_st,
    output logic [TW-1:0] m_tag,
    output logic [DW-1:0] m_data,
    output logic          req_msg_valid,
    output logic [1:0]    req_msg_type,
    output logic [AW-1:0] req_msg_addr,
    output logic [DW-1:0] req_msg_data,
    output logic          cpu_done,
    output logic [DW-1:0] cpu_rdata,
    output fsm_e          state
);

    fsm_e          nxt;
    logic [AW-1:0] addr_q;
    logic          wr_q;
    logic [DW-1:0] wdata_q;
    logic [TW-1:0] vtag_q;
    logic          hit;
    logic          take_miss;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= F_IDLE;
        end else begin
            state <= nxt;
        end
    end

    always_ff @(posedge clk) begin
        if (take_miss) begin
            addr_q  <= cpu_req_addr;
            wr_q    <= cpu_req_write;
            wdata_q <= cpu_req_wdata;
            vtag_q  <= a_tag;
        end
    end

    assign a_idx = (state == F_IDLE) ? cpu_req_addr[IW-1:0] : addr_q[IW-1:0];
    assign hit   = (a_st != LN_INV) && (a_tag == cpu_req_addr[AW-1:IW]) &&
                   ((a_st == LN_EXC) || !cpu_req_write);
    assign take_miss = (state == F_IDLE) && cpu_req_valid && !cmd_busy && !hit;

    always_comb begin
        nxt           = state;
        m_we          = 1'b0;
        m_idx         = a_idx;
        m_st          = LN_INV;
        m_tag         = a_tag;
        m_data        = a_data;
        req_msg_valid = 1'b0;
        req_msg_type  = MSG_RDMISS;
        req_msg_addr  = addr_q;
        req_msg_data  = '0;
        cpu_done      = 1'b0;
        cpu_rdata     = '0;
        unique case (state)
            F_IDLE: begin
                if (cpu_req_valid && !cmd_busy) begin
                    if (hit) begin
                        cpu_done  = 1'b1;
                        cpu_rdata = a_data;
                        if (cpu_req_write) begin
                            m_we   = 1'b1;
                            m_st   = LN_EXC;
                            m_data = cpu_req_wdata;
                        end
                    end else if (a_st == LN_EXC) begin
                        nxt = F_VICTIM;
                    end else begin
                        m_we = 1'b1;
                        m_st = LN_INV;
                        nxt  = F_REQUEST;
                    end
                end
            end
            F_VICTIM: begin
                if (!cmd_busy) begin
                    if (a_st == LN_EXC && a_tag == vtag_q) begin
                        req_msg_valid = 1'b1;
                        req_msg_type  = MSG_WBACK;
                        req_msg_addr  = {vtag_q, addr_q[IW-1:0]};
                        req_msg_data  = a_data;
                    end
                    m_we = 1'b1;
                    m_st = LN_INV;
                    nxt  = F_REQUEST;
                end
            end
            F_REQUEST: begin
                if (!cmd_busy) begin
                    req_msg_valid = 1'b1;
                    req_msg_type  = wr_q ? MSG_WRMISS : MSG_RDMISS;
                    req_msg_addr  = addr_q;
                    nxt           = F_WAIT;
                end
            end
            F_WAIT: begin
                if (reply_valid) begin
                    m_we      = 1'b1;
                    m_st      = wr_q ? LN_EXC : LN_SHR;
                    m_tag     = addr_q[AW-1:IW];
                    m_data    = wr_q ? wdata_q : reply_data;
                    cpu_done  = 1'b1;
                    cpu_rdata = wr_q ? wdata_q : reply_data;
                    nxt       = F_IDLE;
                end
            end
        endcase
    end

endmodule

// File: rtl/coh_cache.sv
module coh_cache
    import coh_pkg::*;
#(
    parameter int AW    = 8,
    parameter int DW    = 16,
    parameter int LINES = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cpu_req_valid,
    input  logic          cpu_req_write,
    input  logic [AW-1:0] cpu_req_addr,
    input  logic [DW-1:0] cpu_req_wdata,
    output logic          cpu_stall,
    output logic          cpu_done,
    output logic [DW-1:0] cpu_rdata,
    input  logic          cmd_valid,
    input  logic [1:0]    cmd_type,
    input  logic [AW-1:0] cmd_addr,
    input  logic          reply_valid,
    input  logic [DW-1:0] reply_data,
    output logic          msg_valid,
    output logic [1:0]    msg_type,
    output logic [AW-1:0] msg_addr,
    output logic [DW-1:0] msg_data
);

    localparam int IW = $clog2(LINES);
    localparam int TW = AW - IW;

    logic [IW-1:0] a_idx, b_idx;
    line_st_e      a_st, b_st, c_st, m_st;
    logic [TW-1:0] a_tag, b_tag, m_tag;
    logic [DW-1:0] a_data, b_data, m_data;
    logic          c_we, m_we;
    logic [IW-1:0] m_idx;
    logic          wb_valid;
    logic [AW-1:0] wb_addr;
    logic [DW-1:0] wb_data;
    logic          req_msg_valid;
    logic [1:0]    req_msg_type;
    logic [AW-1:0] req_msg_addr;
    logic [DW-1:0] req_msg_data;
    fsm_e          fsm_state;

    coh_line_array #(.LINES(LINES), .TW(TW), .DW(DW), .IW(IW)) u_lines (
        .clk(clk), .rst_n(rst_n),
        .a_idx(a_idx), .a_st(a_st), .a_tag(a_tag), .a_data(a_data),
        .b_idx(b_idx), .b_st(b_st), .b_tag(b_tag), .b_data(b_data),
        .c_we(c_we), .c_idx(b_idx), .c_st(c_st),
        .m_we(m_we), .m_idx(m_idx), .m_st(m_st), .m_tag(m_tag), .m_data(m_data)
    );

    coh_cmd_unit #(.AW(AW), .DW(DW), .IW(IW), .TW(TW)) u_cmd (
        .cmd_valid(cmd_valid), .cmd_type(cmd_type), .cmd_addr(cmd_addr),
        .b_idx(b_idx), .b_st(b_st), .b_tag(b_tag), .b_data(b_data),
        .upd_we(c_we), .upd_st(c_st),
        .wb_valid(wb_valid), .wb_addr(wb_addr), .wb_data(wb_data)
    );

    coh_miss_fsm #(.AW(AW), .DW(DW), .IW(IW), .TW(TW)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .cpu_req_valid(cpu_req_valid), .cpu_req_write(cpu_req_write),
        .cpu_req_addr(cpu_req_addr), .cpu_req_wdata(cpu_req_wdata),
        .cmd_busy(cmd_valid),
        .reply_valid(reply_valid), .reply_data(reply_data),
        .a_idx(a_idx), .a_st(a_st), .a_tag(a_tag), .a_data(a_data),
        .m_we(m_we), .m_idx(m_idx), .m_st(m_st), .m_tag(m_tag), .m_data(m_data),
        .req_msg_valid(req_msg_valid), .req_msg_type(req_msg_type),
        .req_msg_addr(req_msg_addr), .req_msg_data(req_msg_data),
        .cpu_done(cpu_done), .cpu_rdata(cpu_rdata), .state(fsm_state)
    );

    // A directory command owns the message port; the request path holds meanwhile
    always_comb begin
        if (wb_valid) begin
            msg_valid = 1'b1;
            msg_type  = MSG_WBACK;
            msg_addr  = wb_addr;
            msg_data  = wb_data;
        end else begin
            msg_valid = req_msg_valid;
            msg_type  = req_msg_type;
            msg_addr  = req_msg_addr;
            msg_data  = req_msg_data;
        end
    end

    assign cpu_stall = cpu_req_valid & ~cpu_done;

endmodule

// File: rtl/coh_cache_chk.sv
module coh_cache_chk
    import coh_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] fsm_state,
    input logic       cmd_valid,
    input logic [1:0] cmd_type,
    input logic       reply_valid,
    input logic       cpu_req_valid,
    input logic       cpu_stall,
    input logic       cpu_done,
    input logic       msg_valid,
    input logic [1:0] msg_type
);

    // R8: a victim write-back step is always followed by the request step
    a_r8_victim_then_request: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == F_VICTIM && !cmd_valid) |=> (fsm_state == F_REQUEST));

    // R2 and R3: the request step emits a miss message, never a write-back
    a_r2_request_emits_miss: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == F_REQUEST && !cmd_valid) |-> (msg_valid && msg_type != MSG_WBACK));

    // R5: an invalidate command never produces a message
    a_r5_invalidate_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_type == CMD_INV) |-> !msg_valid);

    // R9: the processor stays stalled while the reply is outstanding
    a_r9_wait_stalls: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == F_WAIT && !reply_valid && cpu_req_valid) |-> (cpu_stall && !cpu_done));

    // R11: nothing leaves the block while the reply is awaited
    a_r11_quiet_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == F_WAIT && !cmd_valid) |-> !msg_valid);

    // R11: only the three defined message codes appear
    a_r11_type_legal: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |-> (msg_type != 2'd3));

endmodule

bind coh_cache coh_cache_chk u_chk (
    .clk(clk), .rst_n(rst_n), .fsm_state(fsm_state),
    .cmd_valid(cmd_valid), .cmd_type(cmd_type), .reply_valid(reply_valid),
    .cpu_req_valid(cpu_req_valid), .cpu_stall(cpu_stall), .cpu_done(cpu_done),
    .msg_valid(msg_valid), .msg_type(msg_type)
);

// File: tb/coh_cache_tb.sv
module coh_cache_tb;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 8;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cpu_req_valid = 1'b0;
    logic          cpu_req_write = 1'b0;
    logic [AW-1:0] cpu_req_addr = '0;
    logic [DW-1:0] cpu_req_wdata = '0;
    logic          cpu_stall, cpu_done;
    logic [DW-1:0] cpu_rdata;
    logic          cmd_valid = 1'b0;
    logic [1:0]    cmd_type = '0;
    logic [AW-1:0] cmd_addr = '0;
    logic          reply_valid = 1'b0;
    logic [DW-1:0] reply_data = '0;
    logic          msg_valid;
    logic [1:0]    msg_type;
    logic [AW-1:0] msg_addr;
    logic [DW-1:0] msg_data;

    int checks = 0;
    int errors = 0;

    // Model: line state 0 Invalid, 1 Shared, 2 Exclusive
    logic [1:0]    mst   [4];
    logic [5:0]    mtag  [4];
    logic [DW-1:0] mdata [4];
    logic [DW-1:0] mem   [256];

    always #(CLK_PERIOD/2) clk = ~clk;

    coh_cache u_dut (
        .clk(clk), .rst_n(rst_n),
        .cpu_req_valid(cpu_req_valid), .cpu_req_write(cpu_req_write),
        .cpu_req_addr(cpu_req_addr), .cpu_req_wdata(cpu_req_wdata),
        .cpu_stall(cpu_stall), .cpu_done(cpu_done), .cpu_rdata(cpu_rdata),
        .cmd_valid(cmd_valid), .cmd_type(cmd_type), .cmd_addr(cmd_addr),
        .reply_valid(reply_valid), .reply_data(reply_data),
        .msg_valid(msg_valid), .msg_type(msg_type), .msg_addr(msg_addr), .msg_data(msg_data)
    );

    task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    task automatic expect_msg(input string rq, input logic v, input logic [1:0] t,
                              input logic [AW-1:0] a, input logic [DW-1:0] d, input logic with_data);
        chk(rq, "msg_valid", 32'(msg_valid), 32'(v));
        if (v) begin
            chk(rq, "msg_type", 32'(msg_type), 32'(t));
            chk(rq, "msg_addr", 32'(msg_addr), 32'(a));
            if (with_data) chk(rq, "msg_data", 32'(msg_data), 32'(d));
        end
    endtask

    task automatic cpu_access(input logic wr, input logic [AW-1:0] addr, input logic [DW-1:0] wd, input int dly);
        logic [1:0] i;
        logic [5:0] t;
        logic       hit;
        i = addr[1:0];
        t = addr[7:2];
        hit = (mst[i] != 2'd0) && (mtag[i] == t) && (mst[i] == 2'd2 || !wr);
        @(negedge clk);
        cpu_req_valid = 1'b1;
        cpu_req_write = wr;
        cpu_req_addr  = addr;
        cpu_req_wdata = wd;
        #1;
        if (hit) begin
            chk("R4", "hit done", 32'(cpu_done), 32'd1);
            chk("R4", "hit stall", 32'(cpu_stall), 32'd0);
            expect_msg("R4", 1'b0, 2'd0, '0, '0, 1'b0);
            if (!wr) chk("R4", "hit rdata", 32'(cpu_rdata), 32'(mdata[i]));
            else begin
                mdata[i] = wd;
            end
        end else begin
            chk("R9", "miss stall", 32'(cpu_stall), 32'd1);
            chk("R9", "miss done", 32'(cpu_done), 32'd0);
            expect_msg("R11", 1'b0, 2'd0, '0, '0, 1'b0);
            if (mst[i] == 2'd2) begin
                @(negedge clk); #1;
                expect_msg("R8", 1'b1, 2'd2, {mtag[i], i}, mdata[i], 1'b1);
                mem[{mtag[i], i}] = mdata[i];
            end
            @(negedge clk); #1;
            expect_msg(wr ? "R3" : "R2", 1'b1, wr ? 2'd1 : 2'd0, addr, '0, 1'b0);
            chk("R9", "stall at request", 32'(cpu_stall), 32'd1);
            for (int k = 0; k < dly; k++) begin
                @(negedge clk); #1;
                expect_msg("R11", 1'b0, 2'd0, '0, '0, 1'b0);
                chk("R9", "stall in wait", 32'(cpu_stall), 32'd1);
                chk("R9", "done in wait", 32'(cpu_done), 32'd0);
            end
            @(negedge clk);
            reply_valid = 1'b1;
            reply_data  = mem[addr];
            #1;
            chk("R9", "done on reply", 32'(cpu_done), 32'd1);
            chk("R9", "stall on reply", 32'(cpu_stall), 32'd0);
            if (!wr) chk("R2", "miss rdata", 32'(cpu_rdata), 32'(mem[addr]));
            mst[i]   = wr ? 2'd2 : 2'd1;
            mtag[i]  = t;
            mdata[i] = wr ? wd : mem[addr];
        end
        @(posedge clk); #1;
        cpu_req_valid = 1'b0;
        reply_valid   = 1'b0;
    endtask

    task automatic cmd_send(input logic [1:0] ty, input logic [AW-1:0] addr);
        logic [1:0] i;
        logic       match;
        string      rq;
        i = addr[1:0];
        match = (mst[i] != 2'd0) && (mtag[i] == addr[7:2]);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_type  = ty;
        cmd_addr  = addr;
        #1;
        if (match && ty == 2'd0 && mst[i] == 2'd1) begin
            expect_msg("R5", 1'b0, 2'd0, '0, '0, 1'b0);
            mst[i] = 2'd0;
        end else if (match && (ty == 2'd1 || ty == 2'd2) && mst[i] == 2'd2) begin
            rq = (ty == 2'd1) ? "R6" : "R7";
            expect_msg(rq, 1'b1, 2'd2, addr, mdata[i], 1'b1);
            mem[addr] = mdata[i];
            mst[i] = (ty == 2'd1) ? 2'd1 : 2'd0;
        end else begin
            expect_msg("R10", 1'b0, 2'd0, '0, '0, 1'b0);
        end
        @(posedge clk); #1;
        cmd_valid = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        for (int a = 0; a < 256; a++) mem[a] = 16'(a * 37 + 5);
        for (int n = 0; n < 4; n++) begin
            mst[n] = 2'd0; mtag[n] = '0; mdata[n] = '0;
        end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk); #1;
        chk("R1", "stall after reset", 32'(cpu_stall), 32'd0);
        chk("R1", "msg after reset", 32'(msg_valid), 32'd0);
        chk("R1", "done after reset", 32'(cpu_done), 32'd0);

        // Directed corner cases
        cpu_access(1'b0, 8'h05, '0, 1);       // R1/R2 first access misses
        cpu_access(1'b0, 8'h05, '0, 0);       // R4 read hit Shared
        cpu_access(1'b1, 8'h05, 16'hA1B2, 2); // R3 upgrade of Shared line
        cpu_access(1'b1, 8'h05, 16'h1357, 0); // R4 write hit Exclusive
        cpu_access(1'b0, 8'h05, '0, 0);       // R4 read hit Exclusive
        cmd_send(2'd1, 8'h05);                // R6 fetch downgrades
        cpu_access(1'b0, 8'h05, '0, 0);       // Shared read hit after fetch
        cmd_send(2'd0, 8'h05);                // R5 invalidate
        cpu_access(1'b0, 8'h05, '0, 0);       // miss again after invalidate
        cpu_access(1'b1, 8'h09, 16'h00FF, 1);
        cmd_send(2'd2, 8'h09);                // R7 fetch-with-invalidate
        cpu_access(1'b0, 8'h09, '0, 0);       // R2 reads the written-back value
        cpu_access(1'b1, 8'h02, 16'hBEEF, 0);
        cmd_send(2'd0, 8'h02);                // R10 invalidate on Exclusive ignored
        cmd_send(2'd3, 8'h02);                // R10 unused code ignored
        cmd_send(2'd1, 8'h06);                // R10 tag mismatch ignored
        cpu_access(1'b0, 8'h06, '0, 2);       // R8 victim write-back then miss
        cpu_access(1'b0, 8'h02, '0, 0);       // R8 home holds victim data

        // Constrained random mix
        for (int n = 0; n < 600; n++) begin
            int op;
            op = int'($urandom % 4);
            if (op < 2) cpu_access(op[0], 8'($urandom % 16), 16'($urandom), int'($urandom % 3));
            else cmd_send(2'($urandom % 4), 8'($urandom % 16));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule